// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Monitor

This block keeps the atomic reservation of one hardware thread. The decode stage hands it the primary opcode, extended opcode and record bit of the current instruction, the effective address and the source data. A load-reserve opens a reservation on the 128-byte line that holds the address. A later store-conditional commits only if that reservation is still intact. The reservation also records its access width, word or doubleword. A store-conditional of the other width therefore fails, even when its line matches.

A snoop write into the reserved line ends the reservation. So does an external clear, for example on a context switch. In shared-table mode the load-reserve also captures a generation tag from a reservation slot outside this block. The store-conditional then also needs that slot to still hold the same generation for this thread. The result of each store-conditional comes back one cycle later: a done pulse, the condition equal bit, and, on success, a memory write request. The memory itself sits outside the block.

Top module: `resv_monitor`

## Requirements
- R1: After a synchronous reset, valid, width, line and generation all read 0, and neither `sc_done` nor `mem_we` is high.
- R2: A word load-reserve sets valid to 1 and width to 4. A doubleword load-reserve sets valid to 1 and width to 8. Both store the effective address with bits [6:0] cleared as the line. The new state is visible the cycle after the request.
- R3: Decode is done on three fields, all of which must match for a request to be recognised:
  - Primary opcode 31.
  - An extended opcode of 20 (word load-reserve), 84 (doubleword load-reserve), 150 (word store-conditional) or 214 (doubleword store-conditional).
  - For the two store-conditionals, record bit 1.

  Any other combination is ignored: the state is unchanged and no done pulse follows.
- R4: A word store-conditional succeeds only if all three of these hold: valid is set, width is 4, and the store address with bits [6:0] cleared equals the line. A doubleword store-conditional needs width 8 under the same conditions.
- R5: A store-conditional whose width differs from the reservation's width fails. It gives `cr_eq`=0 and no write, even when the line matches.
- R6: Every store-conditional gives a one-cycle `sc_done` pulse in the cycle after the request. `cr_eq` is 1 on success and 0 on failure. `mem_we` is high only with a successful result.
- R7: On a successful commit, `mem_addr` is the store address. A word store drives the low 32 bits of the data, zero-extended, with `mem_dw`=0. A doubleword store drives all 64 bits with `mem_dw`=1.
- R8: After any store-conditional, successful or not, valid and width both read 0.
- R9: A snoop write with its address inside the reserved line clears valid and width on the next clock. A snoop to another line has no effect.
- R10: `clear_req` clears valid and width on the next clock.
- R11: A new load-reserve replaces the whole reservation, including width, line and generation. A load-reserve wins over a snoop hit or a clear arriving in the same cycle.
- R12: A load-reserve with `tbl_en`=1 stores `tbl_gen` as the generation; with `tbl_en`=0 it stores 0. With `tbl_en`=1, a store-conditional also needs `tbl_slot_gen` to equal the stored generation and `tbl_slot_tid` to equal `hw_tid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A decoded instruction is presented |
| req_prim | input | 6 | Primary opcode field |
| req_xo | input | 10 | Extended opcode field |
| req_rc | input | 1 | Record bit |
| req_ea | input | 64 | Effective address |
| req_data | input | 64 | Source data for a store-conditional |
| hw_tid | input | 4 | Thread ID of this hardware thread |
| tbl_en | input | 1 | Shared-table mode enable |
| tbl_gen | input | 8 | Generation handed out by the table on a reserve |
| tbl_slot_gen | input | 8 | Generation currently held by the table slot |
| tbl_slot_tid | input | 4 | Thread ID currently owning the table slot |
| snoop_valid | input | 1 | A write by another agent is observed |
| snoop_addr | input | 64 | Address of the observed write |
| clear_req | input | 1 | External reservation kill |
| sc_done | output | 1 | Store-conditional result pulse |
| cr_eq | output | 1 | Condition equal bit (1 = committed) |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | 64 | Memory write address |
| mem_data | output | 64 | Memory write data |
| mem_dw | output | 1 | 1 = doubleword write, 0 = word write |
| resv_valid | output | 1 | Reservation held |
| resv_width | output | 4 | Reservation width code: 0, 4 or 8 |
| resv_line | output | 64 | Reserved line address |
| resv_gen | output | 8 | Captured generation tag |

## Verification
Requests and kills are driven on the falling edge. A request is taken at the next rising edge, so the reservation state and the store-conditional result outputs are both due one clock after the request. The bench reads them on the falling edge that follows. Each store-conditional pushes its expected result into a queue. The monitor pops an entry only when `sc_done` is seen, which holds it to the one-cycle latency. A done pulse with an empty queue is counted as an error. Memory contents written by a commit are read one extra cycle later, after the monitor has applied the write.

// File: rtl/resv_pkg.sv
package resv_pkg;

    // Instruction field values recognised by the monitor
    localparam logic [5:0] PRIM_ATOMIC = 6'd31;
    localparam logic [9:0] XO_LR_WORD  = 10'd20;
    localparam logic [9:0] XO_LR_DWORD = 10'd84;
    localparam logic [9:0] XO_SC_WORD  = 10'd150;
    localparam logic [9:0] XO_SC_DWORD = 10'd214;

    // Reservation width codes (bytes)
    localparam int         WID_W     = 4;
    localparam logic [3:0] WID_NONE  = 4'd0;
    localparam logic [3:0] WID_WORD  = 4'd4;
    localparam logic [3:0] WID_DWORD = 4'd8;

    localparam int WORD_BITS = 32;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_LR_W,
        OP_LR_D,
        OP_SC_W,
        OP_SC_D
    } op_e;

    typedef struct packed {
        logic       is_lr;
        logic       is_sc;
        logic [3:0] width;
    } op_info_t;

    function automatic op_e classify(input logic [5:0] prim,
                                     input logic [9:0] xo,
                                     input logic       rc);
        op_e r;
        r = OP_NONE;
        if (prim == PRIM_ATOMIC) begin
            case (xo)
                XO_LR_WORD:  r = OP_LR_W;
                XO_LR_DWORD: r = OP_LR_D;
                XO_SC_WORD:  if (rc) r = OP_SC_W;
                XO_SC_DWORD: if (rc) r = OP_SC_D;
                default:     r = OP_NONE;
            endcase
        end
        return r;
    endfunction

    function automatic op_info_t describe(input op_e op);
        op_info_t d;
        d.is_lr = (op == OP_LR_W) || (op == OP_LR_D);
        d.is_sc = (op == OP_SC_W) || (op == OP_SC_D);
        case (op)
            OP_LR_W, OP_SC_W: d.width = WID_WORD;
            OP_LR_D, OP_SC_D: d.width = WID_DWORD;
            default:          d.width = WID_NONE;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/resv_decode.sv
module resv_decode
    import resv_pkg::*;
(
    input  logic       req_valid,
    input  logic [5:0] req_prim,
    input  logic [9:0] req_xo,
    input  logic       req_rc,
    output op_e        op,
    output op_info_t   info
);

    always_comb begin
        op   = req_valid ? classify(req_prim, req_xo, req_rc) : OP_NONE;
        info = describe(op);
    end

endmodule

// File: rtl/resv_state.sv
module resv_state
    import resv_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int LINE_BITS = 7,
    parameter int GEN_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lr_fire,
    input  logic [WID_W-1:0]  lr_width,
    input  logic [ADDR_W-1:0] lr_ea,
    input  logic              tbl_en,
    input  logic [GEN_W-1:0]  tbl_gen,
    input  logic              sc_fire,
    input  logic              clear_req,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              valid_q,
    output logic [WID_W-1:0]  width_q,
    output logic [ADDR_W-1:0] line_q,
    output logic [GEN_W-1:0]  gen_q
);

    localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W'(1) << LINE_BITS) - ADDR_W'(1));

    logic snoop_hit;
    logic kill;

    always_comb begin
        snoop_hit = snoop_valid && valid_q && ((snoop_addr & LINE_MASK) == line_q);
        kill      = sc_fire || clear_req || snoop_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            width_q <= WID_NONE;
            line_q  <= '0;
            gen_q   <= '0;
        end else if (lr_fire) begin
            valid_q <= 1'b1;
            width_q <= lr_width;
            line_q  <= lr_ea & LINE_MASK;
            gen_q   <= tbl_en ? tbl_gen : '0;
        end else if (kill) begin
            valid_q <= 1'b0;
            width_q <= WID_NONE;
        end
    end

endmodule

// File: rtl/resv_commit.sv
module resv_commit
    import resv_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int DATA_W    = 64,
    parameter int LINE_BITS = 7,
    parameter int GEN_W     = 8,
    parameter int TID_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sc_fire,
    input  logic [WID_W-1:0]  sc_width,
    input  logic [ADDR_W-1:0] sc_ea,
    input  logic [DATA_W-1:0] sc_data,
    input  logic              valid_q,
    input  logic [WID_W-1:0]  width_q,
    input  logic [ADDR_W-1:0] line_q,
    input  logic [GEN_W-1:0]  gen_q,
    input  logic              tbl_en,
    input  logic [GEN_W-1:0]  tbl_slot_gen,
    input  logic [TID_W-1:0]  tbl_slot_tid,
    input  logic [TID_W-1:0]  hw_tid,
    output logic              sc_done,
    output logic              cr_eq,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              mem_dw
);

    localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W'(1) << LINE_BITS) - ADDR_W'(1));

    logic              line_hit;
    logic              width_hit;
    logic              table_hit;
    logic              pass;
    logic              is_dw;
    logic [DATA_W-1:0] store_data;

    always_comb begin
        line_hit   = (sc_ea & LINE_MASK) == line_q;
        width_hit  = (width_q == sc_width) && (sc_width != WID_NONE);
        table_hit  = !tbl_en || ((tbl_slot_gen == gen_q) && (tbl_slot_tid == hw_tid));
        pass       = sc_fire && valid_q && width_hit && line_hit && table_hit;
        is_dw      = (sc_width == WID_DWORD);
        store_data = is_dw ? sc_data : DATA_W'(sc_data[WORD_BITS-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sc_done  <= 1'b0;
            cr_eq    <= 1'b0;
            mem_we   <= 1'b0;
            mem_addr <= '0;
            mem_data <= '0;
            mem_dw   <= 1'b0;
        end else begin
            sc_done <= sc_fire;
            cr_eq   <= pass;
            mem_we  <= pass;
            if (sc_fire) begin
                mem_addr <= sc_ea;
                mem_data <= store_data;
                mem_dw   <= is_dw;
            end
        end
    end

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
    import resv_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int DATA_W    = 64,
    parameter int LINE_BITS = 7,
    parameter int GEN_W     = 8,
    parameter int TID_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [5:0]        req_prim,
    input  logic [9:0]        req_xo,
    input  logic              req_rc,
    input  logic [ADDR_W-1:0] req_ea,
    input  logic [DATA_W-1:0] req_data,
    input  logic [TID_W-1:0]  hw_tid,
    input  logic              tbl_en,
    input  logic [GEN_W-1:0]  tbl_gen,
    input  logic [GEN_W-1:0]  tbl_slot_gen,
    input  logic [TID_W-1:0]  tbl_slot_tid,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              clear_req,
    output logic              sc_done,
    output logic              cr_eq,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              mem_dw,
    output logic              resv_valid,
    output logic [3:0]        resv_width,
    output logic [ADDR_W-1:0] resv_line,
    output logic [GEN_W-1:0]  resv_gen
);

    op_e      dec_op;
    op_info_t dec_info;
    logic     is_lr_w;
    logic     is_lr_d;
    logic     is_sc_w;
    logic     is_sc_d;

    resv_decode u_decode (
        .req_valid (req_valid),
        .req_prim  (req_prim),
        .req_xo    (req_xo),
        .req_rc    (req_rc),
        .op        (dec_op),
        .info      (dec_info)
    );

    always_comb begin
        is_lr_w = (dec_op == OP_LR_W);
        is_lr_d = (dec_op == OP_LR_D);
        is_sc_w = (dec_op == OP_SC_W);
        is_sc_d = (dec_op == OP_SC_D);
    end

    resv_state #(
        .ADDR_W    (ADDR_W),
        .LINE_BITS (LINE_BITS),
        .GEN_W     (GEN_W)
    ) u_state (
        .clk         (clk),
        .rst         (rst),
        .lr_fire     (dec_info.is_lr),
        .lr_width    (dec_info.width),
        .lr_ea       (req_ea),
        .tbl_en      (tbl_en),
        .tbl_gen     (tbl_gen),
        .sc_fire     (dec_info.is_sc),
        .clear_req   (clear_req),
        .snoop_valid (snoop_valid),
        .snoop_addr  (snoop_addr),
        .valid_q     (resv_valid),
        .width_q     (resv_width),
        .line_q      (resv_line),
        .gen_q       (resv_gen)
    );

    resv_commit #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .LINE_BITS (LINE_BITS),
        .GEN_W     (GEN_W),
        .TID_W     (TID_W)
    ) u_commit (
        .clk          (clk),
        .rst          (rst),
        .sc_fire      (dec_info.is_sc),
        .sc_width     (dec_info.width),
        .sc_ea        (req_ea),
        .sc_data      (req_data),
        .valid_q      (resv_valid),
        .width_q      (resv_width),
        .line_q       (resv_line),
        .gen_q        (resv_gen),
        .tbl_en       (tbl_en),
        .tbl_slot_gen (tbl_slot_gen),
        .tbl_slot_tid (tbl_slot_tid),
        .hw_tid       (hw_tid),
        .sc_done      (sc_done),
        .cr_eq        (cr_eq),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_data     (mem_data),
        .mem_dw       (mem_dw)
    );

endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk (
    input logic       clk,
    input logic       rst,
    input logic       lr_w,
    input logic       lr_d,
    input logic       sc_w,
    input logic       sc_d,
    input logic       clear_req,
    input logic       sc_done,
    input logic       cr_eq,
    input logic       mem_we,
    input logic       resv_valid,
    input logic [3:0] resv_width
);

    // R6
    done_follows_sc_chk: assert property (@(posedge clk) disable iff (rst)
        (sc_w || sc_d) |=> sc_done);

    // R6
    no_stray_done_chk: assert property (@(posedge clk) disable iff (rst)
        !(sc_w || sc_d) |=> !sc_done);

    // R6
    write_needs_eq_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (sc_done && cr_eq));

    // R8
    sc_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (sc_w || sc_d) |=> (!resv_valid && resv_width == 4'd0));

    // R2
    lr_word_chk: assert property (@(posedge clk) disable iff (rst)
        lr_w |=> (resv_valid && resv_width == 4'd4));

    // R2
    lr_dword_chk: assert property (@(posedge clk) disable iff (rst)
        lr_d |=> (resv_valid && resv_width == 4'd8));

    // R5
    cross_word_chk: assert property (@(posedge clk) disable iff (rst)
        (sc_w && resv_width == 4'd8) |=> (!cr_eq && !mem_we));

    // R5
    cross_dword_chk: assert property (@(posedge clk) disable iff (rst)
        (sc_d && resv_width == 4'd4) |=> (!cr_eq && !mem_we));

    // R10
    clear_kills_chk: assert property (@(posedge clk) disable iff (rst)
        (clear_req && !lr_w && !lr_d) |=> !resv_valid);

    // R1
    width_consistent_chk: assert property (@(posedge clk) disable iff (rst)
        resv_valid ? (resv_width == 4'd4 || resv_width == 4'd8) : (resv_width == 4'd0));

endmodule

bind resv_monitor resv_monitor_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .lr_w       (is_lr_w),
    .lr_d       (is_lr_d),
    .sc_w       (is_sc_w),
    .sc_d       (is_sc_d),
    .clear_req  (clear_req),
    .sc_done    (sc_done),
    .cr_eq      (cr_eq),
    .mem_we     (mem_we),
    .resv_valid (resv_valid),
    .resv_width (resv_width)
);

// File: tb/test_resv_monitor.sv
`timescale 1ns/1ps
module test_resv_monitor;

    localparam logic [63:0] LMASK = ~64'h7F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [5:0]  req_prim = '0;
    logic [9:0]  req_xo = '0;
    logic        req_rc = 1'b0;
    logic [63:0] req_ea = '0;
    logic [63:0] req_data = '0;
    logic [3:0]  hw_tid = 4'd3;
    logic        tbl_en = 1'b0;
    logic [7:0]  tbl_gen = '0;
    logic [7:0]  tbl_slot_gen = '0;
    logic [3:0]  tbl_slot_tid = '0;
    logic        snoop_valid = 1'b0;
    logic [63:0] snoop_addr = '0;
    logic        clear_req = 1'b0;
    logic        sc_done, cr_eq, mem_we, mem_dw, resv_valid;
    logic [63:0] mem_addr, mem_data, resv_line;
    logic [3:0]  resv_width;
    logic [7:0]  resv_gen;

    always #2 clk = ~clk;

    resv_monitor i_resv_monitor (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_prim(req_prim),
        .req_xo(req_xo), .req_rc(req_rc), .req_ea(req_ea), .req_data(req_data),
        .hw_tid(hw_tid), .tbl_en(tbl_en), .tbl_gen(tbl_gen),
        .tbl_slot_gen(tbl_slot_gen), .tbl_slot_tid(tbl_slot_tid),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .clear_req(clear_req),
        .sc_done(sc_done), .cr_eq(cr_eq), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_dw(mem_dw), .resv_valid(resv_valid),
        .resv_width(resv_width), .resv_line(resv_line), .resv_gen(resv_gen)
    );

    int unsigned total = 0;
    int unsigned bad = 0;

    typedef struct {
        bit          ok;
        logic [63:0] addr;
        logic [63:0] data;
        bit          dw;
        string       req;
    } exp_t;
    exp_t q[$];

    logic [63:0] mem [logic [63:0]];

    // reference reservation
    bit          m_valid = 0;
    logic [3:0]  m_width = 0;
    logic [63:0] m_line = 0;
    logic [7:0]  m_gen = 0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] rd(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    // monitor: pops one expected result per done pulse
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (sc_done) begin
                    if (q.size() == 0) begin
                        chk("R6", "unexpected done", 64'd1, 64'd0);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        chk(e.req, "cr_eq", {63'd0, cr_eq}, {63'd0, e.ok});
                        chk("R6", "mem_we", {63'd0, mem_we}, {63'd0, e.ok});
                        if (e.ok && mem_we) begin
                            chk("R7", "mem_addr", mem_addr, e.addr);
                            chk("R7", "mem_data", mem_data, e.data);
                            chk("R7", "mem_dw", {63'd0, mem_dw}, {63'd0, e.dw});
                            mem[mem_addr] = mem_data;
                        end
                    end
                end else if (mem_we) begin
                    chk("R6", "mem_we without done", 64'd1, 64'd0);
                end
            end
        end
    end

    function automatic void apply_kill(input bit sv, input logic [63:0] sa, input bit clr);
        if (clr || (sv && m_valid && ((sa & LMASK) == m_line))) begin
            m_valid = 0;
            m_width = 0;
        end
    endfunction

    task automatic issue(input string req, input logic [5:0] prim, input logic [9:0] xo,
                         input logic rc, input logic [63:0] ea, input logic [63:0] d,
                         input bit sv, input logic [63:0] sa, input bit clr);
        bit is_lr, is_sc;
        logic [3:0] w;
        @(negedge clk);
        is_lr = 0; is_sc = 0; w = 0;
        if (prim == 6'd31) begin
            if (xo == 10'd20)       begin is_lr = 1; w = 4; end
            else if (xo == 10'd84)  begin is_lr = 1; w = 8; end
            else if (xo == 10'd150 && rc) begin is_sc = 1; w = 4; end
            else if (xo == 10'd214 && rc) begin is_sc = 1; w = 8; end
        end
        if (is_lr) begin
            m_valid = 1; m_width = w; m_line = ea & LMASK;
            m_gen = tbl_en ? tbl_gen : 8'd0;
        end else if (is_sc) begin
            exp_t e;
            e.ok = m_valid && (m_width == w) && ((ea & LMASK) == m_line) &&
                   (!tbl_en || (tbl_slot_gen == m_gen && tbl_slot_tid == hw_tid));
            e.addr = ea;
            e.data = (w == 4'd8) ? d : {32'd0, d[31:0]};
            e.dw = (w == 4'd8);
            e.req = req;
            q.push_back(e);
            m_valid = 0; m_width = 0;
        end else begin
            apply_kill(sv, sa, clr);
        end
        req_valid = 1; req_prim = prim; req_xo = xo; req_rc = rc;
        req_ea = ea; req_data = d;
        snoop_valid = sv; snoop_addr = sa; clear_req = clr;
        @(negedge clk);
        req_valid = 0; snoop_valid = 0; clear_req = 0;
    endtask

    task automatic lrw(input logic [63:0] ea);
        issue("R2", 6'd31, 10'd20, 1'b0, ea, 64'd0, 0, 64'd0, 0);
    endtask
    task automatic lrd(input logic [63:0] ea);
        issue("R2", 6'd31, 10'd84, 1'b0, ea, 64'd0, 0, 64'd0, 0);
    endtask
    task automatic scw(input string req, input logic [63:0] ea, input logic [63:0] d);
        issue(req, 6'd31, 10'd150, 1'b1, ea, d, 0, 64'd0, 0);
    endtask
    task automatic scd(input string req, input logic [63:0] ea, input logic [63:0] d);
        issue(req, 6'd31, 10'd214, 1'b1, ea, d, 0, 64'd0, 0);
    endtask

    task automatic kill(input bit sv, input logic [63:0] sa, input bit clr);
        @(negedge clk);
        apply_kill(sv, sa, clr);
        snoop_valid = sv; snoop_addr = sa; clear_req = clr;
        @(negedge clk);
        snoop_valid = 0; clear_req = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_state(input string req);
        chk(req, "resv_valid", {63'd0, resv_valid}, {63'd0, m_valid});
        chk(req, "resv_width", {60'd0, resv_width}, {60'd0, m_width});
        chk(req, "resv_line", resv_line, m_line);
        chk(req, "resv_gen", {56'd0, resv_gen}, {56'd0, m_gen});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst = 0;
        // R1 reset state
        check_state("R1");
        chk("R1", "sc_done", {63'd0, sc_done}, 64'd0);
        chk("R1", "mem_we", {63'd0, mem_we}, 64'd0);

        // R2 word reservation, R4/R7 word commit in same line
        lrw(64'h1010);
        check_state("R2");
        scw("R4", 64'h1040, 64'hDEADBEEF_CAFEBABE);
        check_state("R8");
        idle(1);
        chk("R7", "word memory", rd(64'h1040), 64'h0000_0000_CAFEBABE);

        // R4 no reservation held
        scw("R4", 64'h1040, 64'h1111);

        // R5 word reserve, doubleword conditional
        lrw(64'h1000);
        scd("R5", 64'h1000, 64'hAAAA_BBBB_CCCC_DDDD);
        check_state("R8");
        idle(1);
        chk("R5", "memory untouched", rd(64'h1000), 64'd0);

        // R5 doubleword reserve, word conditional
        lrd(64'h1000);
        scw("R5", 64'h1000, 64'h2222);
        idle(1);
        chk("R5", "memory untouched", rd(64'h1000), 64'd0);

        // R2/R7 doubleword pair
        lrd(64'h2000);
        check_state("R2");
        scd("R7", 64'h2008, 64'h0123_4567_89AB_CDEF);
        idle(1);
        chk("R7", "dword memory", rd(64'h2008), 64'h0123_4567_89AB_CDEF);

        // R4 other line
        lrw(64'h3000);
        scw("R4", 64'h3080, 64'h3333);

        // R9 snoop hit
        lrw(64'h4000);
        kill(1, 64'h4070, 0);
        check_state("R9");
        scw("R9", 64'h4000, 64'h4444);

        // R9 snoop to other line
        lrw(64'h5000);
        kill(1, 64'h5080, 0);
        check_state("R9");
        scw("R9", 64'h5004, 64'h5555);

        // R10 external clear
        lrw(64'h6000);
        kill(0, 64'd0, 1);
        check_state("R10");

        // R11 overwrite and priority over kills
        lrw(64'h7000);
        lrd(64'h8010);
        check_state("R11");
        issue("R11", 6'd31, 10'd20, 1'b0, 64'h9000, 64'd0, 1, 64'h8000, 1);
        check_state("R11");

        // R3 ignored encodings
        issue("R3", 6'd31, 10'd150, 1'b0, 64'h9000, 64'h9, 0, 64'd0, 0);
        check_state("R3");
        issue("R3", 6'd30, 10'd150, 1'b1, 64'h9000, 64'h9, 0, 64'd0, 0);
        check_state("R3");
        scw("R3", 64'h9000, 64'h9999);

        // R12 shared-table mode
        tbl_en = 1; tbl_gen = 8'h5A; tbl_slot_gen = 8'h5A; tbl_slot_tid = 4'd3;
        lrd(64'hA000);
        check_state("R12");
        scd("R12", 64'hA000, 64'hFEED);
        lrw(64'hA000);
        tbl_slot_gen = 8'h5B;
        scw("R12", 64'hA000, 64'h1);
        tbl_slot_gen = 8'h5A;
        lrw(64'hA000);
        tbl_slot_tid = 4'd2;
        scw("R12", 64'hA000, 64'h2);
        tbl_en = 0;
        lrw(64'hB000);
        check_state("R12");

        idle(3);
        chk("R6", "pending results", 64'(q.size()), 64'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule